// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address-Frame Filter

This block receives asynchronous serial frames of ten bit times: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It runs from a single-cycle enable pulse that arrives sixteen times per bit time. Each bit time is therefore cut into sixteen sub-bit states. A frame begins on a high-to-low transition of the line, and that transition restarts the sub-bit counter. Each bit value comes from a two-out-of-three vote over three line samples taken around the middle of the bit. If the start bit votes high, the receiver treats it as noise and goes back to waiting for the next falling edge.

At the stop bit's decision point the receiver offers the byte and the stop-bit value to a pair of holding registers and raises a ready flag. This happens only when the flag is currently clear and, in address-filter mode, only when the stop bit is 1. This lets a node on a shared line ignore data frames and react only to address frames, which are marked by a set stop bit. A frame that fails the condition is dropped and leaves the holding registers untouched. Software-side logic clears the flag with a one-cycle strobe.

The control is a four-state machine:
- PH_IDLE waits for the edge. On a tick with a falling edge it goes to PH_START.
- PH_START votes the start bit. A low vote goes to PH_DATA; a high vote goes back to PH_IDLE.
- PH_DATA shifts in eight bits. After the eighth bit it goes to PH_STOP.
- PH_STOP votes the stop bit, requests the load and always returns to PH_IDLE.

Every bit decision falls on sub-bit state 9.

Top module: `mpf_uart_rx`

## Requirements
- R1: After reset the ready flag is 0, the data holding register is 0x00, the ninth-bit register is 0, and the line is taken as idle high.
- R2: A frame starts only on an oversample tick, while idle, when the synchronized line is low and was high at the previous tick. That tick is sub-bit state 1.
- R3: Each bit value is the majority of the line samples taken on the ticks of sub-bit states 7, 8 and 9. A single disagreeing sample among the three does not change the result.
- R4: If the start bit votes 1, the frame is abandoned, nothing is loaded, the flag is unchanged, and a later valid frame is received normally.
- R5: Data arrives least significant bit first: the first data bit after the start bit lands in bit 0 of the data holding register.
- R6: At the stop bit's state-9 tick, if the flag is 0 and either address-filter mode is off or the stop bit voted 1, the byte goes to the data register, the stop-bit value goes to the ninth-bit register, and the flag becomes 1. With the filter off, a stop bit of 0 is still loaded as 0.
- R7: A frame that completes while the flag is 1 is discarded: the data register, the ninth-bit register and the flag keep their values.
- R8: With address-filter mode on (`addr_filt_en`=1), a frame whose stop bit votes 0 is discarded and leaves the holding registers and the flag unchanged.
- R9: The flag stays 1 until a cycle with `flag_clr`=1, which makes it 0 on the next edge.
- R10: When a load and `flag_clr` fall in the same cycle, the flag ends up 1 and the new frame is held.
- R11: The receiver is idle again from the stop bit's state-9 tick on, so a start bit that directly follows a stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line, idles high |
| os_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| addr_filt_en | input | 1 | 1 drops frames whose stop bit is 0 |
| flag_clr | input | 1 | One-cycle strobe that clears the ready flag |
| rx_byte | output | 8 | Data holding register |
| rx_bit9 | output | 1 | Stop-bit value of the last loaded frame |
| rx_flag | output | 1 | Ready flag: a frame has been loaded |

## Verification
Two situations are hard to reach from the ports.

The first is a clear strobe landing in the exact cycle of a load. The bench drives the line one oversample slot at a time, aligned to the tick stream it generates itself. Because of that, it knows which tick is the stop bit's state 9, and it raises `flag_clr` for the one cycle in which that tick is consumed.

The second is a single outvoted sample. The same slot-level driver inverts the line for exactly one of sub-states 7, 8 or 9 in every bit of a frame. It also cuts start pulses short at seven slots, so that the vote falls just on the reject side.

// File: rtl/mpf_rx_pkg.sv
package mpf_rx_pkg;

    // Receiver control phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_e;

    // Two-out-of-three majority
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mpf_rx_sync.sv
// Line synchronizer plus tick-sampled history for falling-edge detection.
module mpf_rx_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic tick,
    output logic line_s,
    output logic fall_seen
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
        end
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // Line level at the previous oversample tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else if (tick) begin
            prev_q <= line_s;
        end
    end

    assign fall_seen = prev_q & ~line_s;

endmodule

// File: rtl/mpf_rx_sampler.sv
// Sub-bit counter and three-sample majority voter.
module mpf_rx_sampler #(
    parameter int OS_RATE     = 16,
    parameter int VOTE_CENTER = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic run,
    input  logic line_s,
    output logic bit_ready,
    output logic bit_val
);
    import mpf_rx_pkg::*;

    localparam int CW = $clog2(OS_RATE + 1);
    localparam logic [CW-1:0] ST_FIRST = CW'(1);
    localparam logic [CW-1:0] ST_LAST  = CW'(OS_RATE);
    localparam logic [CW-1:0] ST_EARLY = CW'(VOTE_CENTER - 1);
    localparam logic [CW-1:0] ST_MID   = CW'(VOTE_CENTER);
    localparam logic [CW-1:0] ST_LATE  = CW'(VOTE_CENTER + 1);

    logic [CW-1:0] sub_q;
    logic [CW-1:0] sub_nxt;
    logic          smp_early_q;
    logic          smp_mid_q;

    // State the counter enters on this tick
    always_comb begin
        if (sub_q == ST_LAST) begin
            sub_nxt = ST_FIRST;
        end else begin
            sub_nxt = sub_q + ST_FIRST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (tick) begin
            if (restart) begin
                sub_q <= ST_FIRST;
            end else if (run) begin
                sub_q <= sub_nxt;
            end else begin
                sub_q <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_early_q <= 1'b1;
            smp_mid_q   <= 1'b1;
        end else if (tick && run) begin
            if (sub_nxt == ST_EARLY) begin
                smp_early_q <= line_s;
            end
            if (sub_nxt == ST_MID) begin
                smp_mid_q <= line_s;
            end
        end
    end

    assign bit_ready = tick && run && !restart && (sub_nxt == ST_LATE);
    assign bit_val   = maj3(smp_early_q, smp_mid_q, line_s);

endmodule

// File: rtl/mpf_rx_hold.sv
// Holding registers, ready flag and the load gate.
module mpf_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic              stop_val,
    input  logic [DATA_W-1:0] data_in,
    input  logic              filt_en,
    input  logic              clr,
    output logic [DATA_W-1:0] hold_byte,
    output logic              hold_bit9,
    output logic              flag,
    output logic              accept
);
    logic [DATA_W-1:0] byte_q;
    logic              bit9_q;
    logic              flag_q;

    assign accept = frame_done && !flag_q && (!filt_en || stop_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            bit9_q <= 1'b0;
        end else if (accept) begin
            byte_q <= data_in;
            bit9_q <= stop_val;
        end
    end

    // A load beats a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (accept) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign hold_byte = byte_q;
    assign hold_bit9 = bit9_q;
    assign flag      = flag_q;

endmodule

// File: rtl/mpf_uart_rx.sv
// Oversampling serial receiver with address-frame filter (top).
module mpf_uart_rx #(
    parameter int DATA_W      = 8,
    parameter int OS_RATE     = 16,
    parameter int VOTE_CENTER = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              os_tick,
    input  logic              addr_filt_en,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_flag
);
    import mpf_rx_pkg::*;

    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rx_phase_e         state_q;
    rx_phase_e         state_d;
    logic              line_s;
    logic              fall_seen;
    logic              start_go;
    logic              bit_ready;
    logic              bit_val;
    logic              frame_done;
    logic              load_go;
    logic [DATA_W-1:0] shift_q;
    logic [BW-1:0]     bcnt_q;

    mpf_rx_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rx_line),
        .tick     (os_tick),
        .line_s   (line_s),
        .fall_seen(fall_seen)
    );

    assign start_go = (state_q == PH_IDLE) && os_tick && fall_seen;

    mpf_rx_sampler #(
        .OS_RATE    (OS_RATE),
        .VOTE_CENTER(VOTE_CENTER)
    ) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .restart  (start_go),
        .run      (state_q != PH_IDLE),
        .line_s   (line_s),
        .bit_ready(bit_ready),
        .bit_val  (bit_val)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start_go) state_d = PH_START;
            end
            PH_START: begin
                if (bit_ready) state_d = bit_val ? PH_IDLE : PH_DATA;
            end
            PH_DATA: begin
                if (bit_ready && (bcnt_q == LAST_BIT)) state_d = PH_STOP;
            end
            PH_STOP: begin
                if (bit_ready) state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath outputs of the machine: shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bcnt_q  <= '0;
        end else if (bit_ready) begin
            unique case (state_q)
                PH_START: bcnt_q <= '0;
                PH_DATA: begin
                    shift_q <= {bit_val, shift_q[DATA_W-1:1]};
                    bcnt_q  <= bcnt_q + BW'(1);
                end
                default: ;
            endcase
        end
    end

    assign frame_done = (state_q == PH_STOP) && bit_ready;

    mpf_rx_hold #(
        .DATA_W(DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .stop_val  (bit_val),
        .data_in   (shift_q),
        .filt_en   (addr_filt_en),
        .clr       (flag_clr),
        .hold_byte (rx_byte),
        .hold_bit9 (rx_bit9),
        .flag      (rx_flag),
        .accept    (load_go)
    );

endmodule

// File: rtl/mpf_uart_rx_chk.sv
module mpf_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  os_tick,
    input logic                  addr_filt_en,
    input logic                  flag_clr,
    input logic [DATA_W-1:0]     rx_byte,
    input logic                  rx_bit9,
    input logic                  rx_flag,
    input logic                  load_go,
    input mpf_rx_pkg::rx_phase_e state_q
);
    import mpf_rx_pkg::*;

    // R2: the machine leaves idle only on a tick
    a_r2_idle_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE) && !os_tick |=> (state_q == PH_IDLE));

    // R6: a load is only offered when the flag is clear, and then sets it
    a_r6_load_needs_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |-> !rx_flag);
    a_r6_load_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> rx_flag);

    // R7: without a load, the holding registers do not move
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_go |=> $stable(rx_byte) && $stable(rx_bit9));

    // R8: in filter mode, only frames with a set stop bit are loaded
    a_r8_filter_bit9: assert property (@(posedge clk) disable iff (!rst_n)
        load_go && addr_filt_en |=> rx_bit9);

    // R9: the flag holds until cleared, and a clear without a load drops it
    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag && !flag_clr |=> rx_flag);
    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag && flag_clr && !load_go |=> !rx_flag);

    // R10: set wins over a same-cycle clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_go && flag_clr |=> rx_flag);

endmodule

bind mpf_uart_rx mpf_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .os_tick     (os_tick),
    .addr_filt_en(addr_filt_en),
    .flag_clr    (flag_clr),
    .rx_byte     (rx_byte),
    .rx_bit9     (rx_bit9),
    .rx_flag     (rx_flag),
    .load_go     (load_go),
    .state_q     (state_q)
);

// File: tb/mpf_uart_rx_tb.sv
`timescale 1ns/1ps
module mpf_uart_rx_tb;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       os_tick = 1'b0;
    logic       addr_filt_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_flag;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb_q[$];
    logic model_flag = 1'b0;
    logic [7:0] last_byte = 8'h00;
    logic       last_bit9 = 1'b0;
    int   tick_cnt = 0;
    logic flag_prev = 1'b0;

    mpf_uart_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .os_tick     (os_tick),
        .addr_filt_en(addr_filt_en),
        .flag_clr    (flag_clr),
        .rx_byte     (rx_byte),
        .rx_bit9     (rx_bit9),
        .rx_flag     (rx_flag)
    );

    always #2.5 clk = ~clk;

    // Oversample tick: one cycle in four
    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
        os_tick  <= (tick_cnt == 2);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Return just after the next tick has been consumed by a posedge
    task automatic wait_tick(input bit clr);
        do @(negedge clk); while (!os_tick);
        if (clr) flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic idle_slots(input int n);
        rx_line = 1'b1;
        for (int i = 0; i < n; i++) wait_tick(1'b0);
    endtask

    // Driver: one slot per tick, 16 slots per bit; gslot inverts one slot per bit
    task automatic send_frame(input logic [7:0] d, input logic stop, input int gslot,
                              input bit clr_first, input bit clr_at_load);
        logic bv;
        logic exp_load;
        if (clr_first) model_flag = 1'b0;
        exp_load = !model_flag && (!addr_filt_en || stop);
        if (exp_load) begin
            sb_q.push_back('{data: d, bit9: stop});
            model_flag = 1'b1;
            last_byte  = d;
            last_bit9  = stop;
        end
        for (int b = 0; b < 10; b++) begin
            bv = (b == 0) ? 1'b0 : ((b == 9) ? stop : d[b-1]);
            for (int s = 1; s <= 16; s++) begin
                rx_line = bv ^ (s == gslot);
                wait_tick((clr_first && b == 0 && s == 1) ||
                          (clr_at_load && b == 9 && s == 9));
            end
        end
        rx_line = 1'b1;
    endtask

    // Short low pulse that must be rejected as a start bit
    task automatic send_false(input int low_slots);
        rx_line = 1'b0;
        for (int s = 0; s < low_slots; s++) wait_tick(1'b0);
        idle_slots(20);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        model_flag = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on each rising flag
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_flag && !flag_prev) begin
                if (sb_q.size() == 0) begin
                    check("R7/R8 unexpected load", {23'd0, rx_bit9, rx_byte}, 32'hFFFF);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check("R5/R6 loaded byte", rx_byte, e.data);
                    check("R6 loaded bit9", rx_bit9, e.bit9);
                end
            end
            flag_prev = rx_flag;
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        n_errors++;
        n_checks++;
        $display("FAIL R11 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flag", rx_flag, 0);
        check("R1 byte", rx_byte, 8'h00);
        check("R1 bit9", rx_bit9, 0);

        idle_slots(4);
        // R6 basic load, R9 flag hold then clear
        send_frame(8'hA5, 1'b1, 0, 0, 0);
        idle_slots(8);
        check("R9 flag held", rx_flag, 1);
        clear_flag();
        check("R9 flag cleared", rx_flag, 0);

        // R5 bit order
        send_frame(8'h01, 1'b1, 0, 0, 0); clear_flag();
        send_frame(8'h80, 1'b1, 0, 0, 0); clear_flag();
        check("R5 msb lands high", rx_byte, 8'h80);

        // R3 single outvoted sample in every bit
        send_frame(8'h3C, 1'b1, 7, 0, 0); clear_flag();
        send_frame(8'hC3, 1'b1, 8, 0, 0); clear_flag();
        send_frame(8'h69, 1'b1, 9, 0, 0); clear_flag();
        check("R3 vote slot9 byte", rx_byte, 8'h69);

        // R4 false starts, then recovery
        send_false(7);
        check("R4 no flag after 7-slot pulse", rx_flag, 0);
        check("R4 byte kept", rx_byte, last_byte);
        send_false(1);
        check("R4 no flag after 1-slot pulse", rx_flag, 0);
        send_frame(8'h96, 1'b1, 0, 0, 0); clear_flag();
        check("R4 recovery byte", rx_byte, 8'h96);

        // R7 pending flag drops the next frame
        send_frame(8'h11, 1'b0, 0, 0, 0);
        idle_slots(4);
        send_frame(8'h22, 1'b1, 0, 0, 0);
        idle_slots(4);
        check("R7 byte kept", rx_byte, 8'h11);
        check("R7 bit9 kept", rx_bit9, 0);
        check("R7 flag still set", rx_flag, 1);
        clear_flag();

        // R8 address filter
        addr_filt_en = 1'b1;
        send_frame(8'h5A, 1'b0, 0, 0, 0);
        idle_slots(4);
        check("R8 data frame dropped flag", rx_flag, 0);
        check("R8 data frame dropped byte", rx_byte, 8'h11);
        send_frame(8'h6B, 1'b1, 0, 0, 0);
        idle_slots(4);
        check("R8 address frame bit9", rx_bit9, 1);
        clear_flag();
        addr_filt_en = 1'b0;
        send_frame(8'h77, 1'b0, 0, 0, 0);
        idle_slots(4);
        check("R6 stop 0 loaded when filter off", rx_bit9, 0);
        clear_flag();

        // R10 clear in the load cycle
        send_frame(8'hE7, 1'b1, 0, 0, 1);
        idle_slots(2);
        check("R10 flag set wins", rx_flag, 1);
        check("R10 byte", rx_byte, 8'hE7);
        clear_flag();

        // R11 back-to-back frames, clear at second start
        send_frame(8'h4D, 1'b1, 0, 0, 0);
        send_frame(8'hB2, 1'b1, 0, 1, 0);
        idle_slots(4);
        check("R11 second frame byte", rx_byte, 8'hB2);
        check("R11 second frame flag", rx_flag, 1);
        clear_flag();

        idle_slots(4);
        check("R6 scoreboard drained", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule